// File: doc/BRIEF.md
# Write Completion Polling Responder

This block sits in the read path of a banked, word-wide non-volatile memory. It lets a host learn when an internal programming cycle has ended without knowing how long that cycle takes. Each accepted word load is remembered, both its location (bank and word address) and its value. While the write controller reports that programming is still running, a read of that remembered location returns the array contents with the top bit of every byte lane replaced by the inverse of the bit that was written. The host keeps reading that location until the top bits match what it wrote.

All other reads return the array data unchanged. When the controller drops its busy flag, the next registered read result carries the true contents on every bit. The bus controls are active-low. There is one chip select per bank, one output enable and one write enable. The outputs are a registered data word and a drive-enable that an outer pad ring uses for tristate control.

Top module: `poll_responder`

## Requirements
- R1: On synchronous reset `rd_en` and `rd_data` are 0 and no location is remembered, so a busy read of any address returns `arr_data` unmodified until a word is loaded.
- R2: One cycle after a read cycle (exactly one `cs_n` bit low, `oe_n` low, `we_n` high), `rd_en` is 1. With `busy` low, `rd_data` then equals the `arr_data` presented in that cycle.
- R3: When no read cycle is presented (no select, or `oe_n` high, or `we_n` low), `rd_en` and `rd_data` are 0 one cycle later.
- R4: A cycle with more than one `cs_n` bit low never drives: `rd_en` is 0 one cycle later.
- R5: A cycle with exactly one `cs_n` bit low, `oe_n` high and `we_n` low is a word load. It stores the bank index (the position of the low select bit) with `addr`, and stores `wr_data`. A later load replaces the stored word.
- R6: During `busy`, a read of the stored bank and address returns `arr_data`, except that bits 7 and 15 (bit 8k+7 of each byte lane k) are the complement of the stored data's same bits.
- R7: During `busy`, a read of any other bank or address returns `arr_data` unmodified.
- R8: When `busy` is low, reads return `arr_data` on all bits. The first read result registered after `busy` falls already carries the true top bits.
- R9: Polling may start on the first cycle after the load and repeat for as long as `busy` holds, giving the inverted flags each time.
- R10: A cycle with `oe_n` and `we_n` both low neither drives nor loads, and the stored word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Programming in progress, from the write controller |
| cs_n | input | NBANK (4) | Active-low bank selects |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | AW (17) | Word address within a bank |
| wr_data | input | DW (16) | Word presented on a load |
| arr_data | input | DW (16) | Array read data for the addressed word |
| rd_data | output | DW (16) | Registered read result |
| rd_en | output | 1 | Registered drive enable for the data bus |

## Verification
Polling reads are tried on the stored location with array words that have the flag bits set, clear and mixed. This shows that the flags are inverted from the written value rather than from the array, and that the lower bits still come from the array. Reads at the same address in another bank, and at a neighbouring address in the same bank, show that the match covers the bank and the full address. Write cycles with output enable low, cycles with several selects low, and a second load made during busy show which cycles may change the stored word. A read held steady across the fall of busy shows the one-cycle change to true data.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_LOAD,
        BUS_CONFLICT
    } bus_op_e;

    // Classify one bus cycle from the strobes and the number of selected banks.
    function automatic bus_op_e classify(input logic oe_n, input logic we_n,
                                         input int unsigned n_sel);
        bus_op_e op;
        op = BUS_IDLE;
        if (n_sel > 1) begin
            op = BUS_CONFLICT;
        end else if (n_sel == 1) begin
            if (!oe_n && we_n) begin
                op = BUS_READ;
            end else if (oe_n && !we_n) begin
                op = BUS_LOAD;
            end
        end
        return op;
    endfunction

endpackage

// File: rtl/poll_bus_decode.sv
module poll_bus_decode
    import poll_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [NBANK-1:0] cs_n,
    input  logic             oe_n,
    input  logic             we_n,
    output bus_op_e          op,
    output logic [BW-1:0]    bank
);

    int unsigned n_sel;

    always_comb begin
        n_sel = 0;
        bank  = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (!cs_n[b]) begin
                n_sel = n_sel + 1;
                bank  = BW'(b);
            end
        end
        op = classify(oe_n, we_n, n_sel);
    end

endmodule

// File: rtl/poll_last_word.sv
module poll_last_word #(
    parameter int TW = 19,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] tag_in,
    input  logic [DW-1:0] data_in,
    output logic          held,
    output logic [TW-1:0] tag_q,
    output logic [DW-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            held   <= 1'b1;
            tag_q  <= tag_in;
            data_q <= data_in;
        end
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        load |=> (held && data_q == $past(data_in) && tag_q == $past(tag_in))); // R5

endmodule

// File: rtl/poll_status_mux.sv
module poll_status_mux #(
    parameter int TW = 19,
    parameter int DW = 16,
    localparam int LANES = DW / poll_pkg::LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy,
    input  logic [TW-1:0] rd_tag,
    input  logic          held,
    input  logic [TW-1:0] last_tag,
    input  logic [DW-1:0] last_data,
    input  logic [DW-1:0] arr_data,
    output logic          hit,
    output logic [DW-1:0] data_o
);

    logic [DW-1:0] flag_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign flag_mask[l*poll_pkg::LANE_W +: poll_pkg::LANE_W] =
            {1'b1, {(poll_pkg::LANE_W-1){1'b0}}};
    end

    always_comb begin
        hit    = busy && held && (rd_tag == last_tag);
        data_o = hit ? ((arr_data & ~flag_mask) | (~last_data & flag_mask))
                     : arr_data;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !hit |-> data_o == arr_data); // R7

    AST_IDLE_TRUE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> data_o == arr_data); // R8

endmodule

// File: rtl/poll_responder.sv
module poll_responder
    import poll_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 17,
    parameter int DW    = 16,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int TW   = BW + AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [NBANK-1:0] cs_n,
    input  logic             oe_n,
    input  logic             we_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW-1:0]    arr_data,
    output logic [DW-1:0]    rd_data,
    output logic             rd_en
);

    bus_op_e       op;
    logic [BW-1:0] bank;
    logic [TW-1:0] cur_tag;
    logic          held;
    logic [TW-1:0] last_tag;
    logic [DW-1:0] last_data;
    logic          hit;
    logic [DW-1:0] poll_word;

    poll_bus_decode #(.NBANK(NBANK)) u_dec (
        .cs_n (cs_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .op   (op),
        .bank (bank)
    );

    assign cur_tag = {bank, addr};

    poll_last_word #(.TW(TW), .DW(DW)) u_last (
        .clk     (clk),
        .rst     (rst),
        .load    (op == BUS_LOAD),
        .tag_in  (cur_tag),
        .data_in (wr_data),
        .held    (held),
        .tag_q   (last_tag),
        .data_q  (last_data)
    );

    poll_status_mux #(.TW(TW), .DW(DW)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .rd_tag    (cur_tag),
        .held      (held),
        .last_tag  (last_tag),
        .last_data (last_data),
        .arr_data  (arr_data),
        .hit       (hit),
        .data_o    (poll_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_en   <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_en   <= (op == BUS_READ);
            rd_data <= (op == BUS_READ) ? poll_word : '0;
        end
    end

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
        ($countones(~cs_n) == 1 && !oe_n && we_n) |=> rd_en); // R2

    AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> (!rd_en && rd_data == '0)); // R3

    AST_MULTI_SEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($countones(~cs_n) > 1) |=> !rd_en); // R4

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && !we_n) |=> ($stable(last_data) && $stable(last_tag))); // R10

    AST_TRUE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && $countones(~cs_n) == 1 && !oe_n && we_n)
            |=> rd_data == $past(arr_data)); // R8

endmodule

// File: tb/sim_poll_responder.sv
`timescale 1ns/1ps
module sim_poll_responder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy = 1'b0;
    logic [3:0]  cs_n = 4'hF;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] arr_data = '0;
    logic [15:0] rd_data;
    logic        rd_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    poll_responder u0 (
        .clk(clk), .rst(rst), .busy(busy), .cs_n(cs_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .wr_data(wr_data), .arr_data(arr_data),
        .rd_data(rd_data), .rd_en(rd_en)
    );

    typedef struct packed {
        logic        busy;
        logic [3:0]  cs_n;
        logic        oe_n;
        logic        we_n;
        logic [16:0] addr;
        logic [15:0] wdat;
        logic [15:0] arr;
        logic        en;
        logic [15:0] dat;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'b1110, 1'b0, 1'b1, 17'h05555, 16'h0000, 16'h1234, 1'b1, 16'h1234, 8'd1},  // R1 nothing held
        '{1'b0, 4'b1101, 1'b1, 1'b0, 17'h00010, 16'hA5C3, 16'h0000, 1'b0, 16'h0000, 8'd5},  // R5 load bank1
        '{1'b1, 4'b1101, 1'b0, 1'b1, 17'h00010, 16'h0000, 16'hFFFF, 1'b1, 16'h7F7F, 8'd6},  // R6
        '{1'b1, 4'b1101, 1'b0, 1'b1, 17'h00010, 16'h0000, 16'h8181, 1'b1, 16'h0101, 8'd9},  // R9 repeat poll
        '{1'b1, 4'b1011, 1'b0, 1'b1, 17'h00010, 16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 8'd7},  // R7 other bank
        '{1'b1, 4'b1101, 1'b0, 1'b1, 17'h00011, 16'h0000, 16'hABCD, 1'b1, 16'hABCD, 8'd7},  // R7 other addr
        '{1'b0, 4'b1101, 1'b0, 1'b1, 17'h00010, 16'h0000, 16'hA5C3, 1'b1, 16'hA5C3, 8'd8},  // R8 not busy
        '{1'b0, 4'b0111, 1'b1, 1'b0, 17'h1FFFF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 8'd3},  // R3 load cycle quiet
        '{1'b1, 4'b0111, 1'b0, 1'b1, 17'h1FFFF, 16'h0000, 16'h1234, 1'b1, 16'h92B4, 8'd6},  // R6 flags set
        '{1'b1, 4'b0111, 1'b0, 1'b0, 17'h1FFFF, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 8'd10}, // R10 inhibited
        '{1'b1, 4'b0111, 1'b0, 1'b1, 17'h1FFFF, 16'h0000, 16'h0000, 1'b1, 16'h8080, 8'd10}, // R10 word kept
        '{1'b0, 4'b1100, 1'b0, 1'b1, 17'h00000, 16'h0000, 16'h5A5A, 1'b0, 16'h0000, 8'd4},  // R4 two selects
        '{1'b0, 4'b1111, 1'b0, 1'b1, 17'h00000, 16'h0000, 16'h5A5A, 1'b0, 16'h0000, 8'd3},  // R3 no select
        '{1'b0, 4'b1110, 1'b1, 1'b1, 17'h00000, 16'h0000, 16'h5A5A, 1'b0, 16'h0000, 8'd3},  // R3 oe high
        '{1'b1, 4'b1110, 1'b1, 1'b0, 17'h00000, 16'h0080, 16'h0000, 1'b0, 16'h0000, 8'd5},  // R5 reload in busy
        '{1'b1, 4'b1110, 1'b0, 1'b1, 17'h00000, 16'h0000, 16'h0000, 1'b1, 16'h8000, 8'd6},  // R6 mixed flags
        '{1'b1, 4'b0111, 1'b0, 1'b1, 17'h1FFFF, 16'h0000, 16'h0000, 1'b1, 16'h0000, 8'd5}   // R5 old word gone
    };

    task automatic check(input string req, input logic en_exp, input logic [15:0] d_exp);
        checks++;
        if (rd_en !== en_exp || rd_data !== d_exp) begin
            errors++;
            $display("FAIL %s: rd_en=%0b rd_data=%h expected rd_en=%0b rd_data=%h",
                     req, rd_en, rd_data, en_exp, d_exp);
        end
    endtask

    task automatic drive(input logic b, input logic [3:0] cs, input logic oe,
                         input logic we, input logic [16:0] a,
                         input logic [15:0] w, input logic [15:0] ar);
        @(negedge clk);
        busy = b; cs_n = cs; oe_n = oe; we_n = we;
        addr = a; wr_data = w; arr_data = ar;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", 1'b0, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].busy, VECS[i].cs_n, VECS[i].oe_n, VECS[i].we_n,
                  VECS[i].addr, VECS[i].wdat, VECS[i].arr);
            check($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].en, VECS[i].dat);
        end

        // R8: flag returns to true one clock after busy falls
        drive(1'b1, 4'b1011, 1'b1, 1'b0, 17'h00100, 16'h0080, 16'h0000);
        drive(1'b1, 4'b1011, 1'b0, 1'b1, 17'h00100, 16'h0000, 16'h0080);
        check("R9 first poll", 1'b1, 16'h8000);
        drive(1'b0, 4'b1011, 1'b0, 1'b1, 17'h00100, 16'h0000, 16'h0080);
        check("R8 busy fell", 1'b1, 16'h0080);

        // R1: reset during a read, then the stored word is forgotten
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset mid read", 1'b0, 16'h0000);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 4'b1011, 1'b0, 1'b1, 17'h00100, 16'h0000, 16'hFFFF);
        check("R1 store cleared", 1'b1, 16'hFFFF);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule